// File: doc/BRIEF.md
# Parallel DMA User-Port Handshake Controller

This block sits between a 16-bit parallel user port and an internal DMA engine. It decides when one data word may move. A rising edge on either of two OR-combined cycle-request inputs starts one transfer, but only while READY is low. Each transfer drives BUSY active, asks the DMA engine for a word, and holds BUSY active for a minimum setup time and a minimum active time. It then drops BUSY and emits an ENDCY pulse of fixed width. In burst mode the next transfer starts on its own after ENDCY. In single-cycle mode each transfer waits for a fresh request.

Software drives the block through plain control pins. One pin writes the GO bit, which clears READY and emits a GO pulse. Another writes the three function bits. Setting function bit 2 fires an INITV2 pulse. A further pin is a software INIT level. Two configuration pins select the BUSY polarity and the slow or fast timing set. A status byte mirrors the user status lines.

ATTN from the user, or a bus error from the DMA side, aborts the transfer in progress and sets READY. All timing is counted in system clocks, and every count is a parameter.

The DMA side is a valid/ready request channel. `dma_req_valid` rises when a transfer needs a word. It stays high, with `dma_req_dir` held steady, until the engine raises `dma_req_ready`, and the word moves on the cycle where both are high. Only an abort (ATTN, a bus error or reset) may withdraw a pending request.

Top module: `dma_user_handshake`

## Requirements
- R1: During reset READY, INIT and INITV2 are high, BUSY is inactive, ENDCY is low and no DMA request is pending.
- R2: Writing GO clears READY and drives `usr_go` high for exactly GO_CLKS (20) clocks.
- R3: A rising edge of (`usr_cycrq_a` OR `usr_cycrq_b`) starts a transfer only when READY is low. With READY high the edge is dropped: no BUSY, no DMA request, and it is not remembered.
- R4: A high ATTN or a `bus_err` pulse sets READY, ends any transfer (BUSY inactive, no DMA request) and cancels any pending request. Both override a GO write in the same cycle.
- R5: Every completed transfer ends with ENDCY high for exactly ENDCY_CLKS (10) clocks, and ENDCY is never high together with active BUSY.
- R6: With `ctl_busy_hi` = 0, `usr_busy` is low while active. With `ctl_busy_hi` = 1, it is high while active.
- R7: In burst mode (`usr_single` = 0), BUSY stays active for exactly max(BUSY_MIN, request wait + setup) clocks. BUSY_MIN is 30 in fast mode and 50 in slow mode (`ctl_slow` = 1). The next transfer follows each ENDCY with no new request.
- R8: In single-cycle mode, an output transfer (`usr_dir_in` = 0) keeps BUSY active for its request wait plus SETUP clocks after the word handshake. SETUP is 20 in fast mode and 40 in slow mode. An input transfer (`usr_dir_in` = 1) releases BUSY one clock after the handshake.
- R9: A request edge that arrives during a transfer is held as pending and starts one more transfer after ENDCY. It is discarded if READY is set in the meantime.
- R10: A function write places `ctl_fn_data` on `usr_fnct`. A write that changes bit 1 from 0 to 1 drives `usr_initv2` high for exactly INITV2_CLKS (20) clocks. `usr_init` follows `ctl_init_sw`.
- R11: `status_byte` holds READY in bit 7, STATA/STATB/STATC (`usr_stat[2]`, `[1]`, `[0]`) in bits 5, 4 and 3, C0 in bit 1 and A0 in bit 0. Bits 6 and 2 read zero.
- R12: `dma_req_valid` stays high with `dma_req_dir` unchanged until `dma_req_ready` is seen, unless an abort occurs. `dma_req_dir` equals `usr_dir_in` as sampled when the transfer started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_go_wr | input | 1 | One-clock software write of a one to GO |
| ctl_fn_wr | input | 1 | One-clock software write of the function bits |
| ctl_fn_data | input | 3 | Function bits to write (bit 1 is FNCT2) |
| ctl_init_sw | input | 1 | Software INIT level |
| ctl_busy_hi | input | 1 | 1 selects active-high BUSY |
| ctl_slow | input | 1 | 1 selects the slow timing set |
| bus_err | input | 1 | One-clock bus error from the DMA side |
| status_byte | output | 8 | Readable status byte |
| usr_cycrq_a | input | 1 | Cycle request A |
| usr_cycrq_b | input | 1 | Cycle request B |
| usr_attn | input | 1 | User attention (abort) |
| usr_dir_in | input | 1 | 1: data flows from the user into the block |
| usr_c0 | input | 1 | User control bit 0, status only |
| usr_a0 | input | 1 | User address bit 0, status only |
| usr_stat | input | 3 | User status lines A, B, C |
| usr_single | input | 1 | 1: single-cycle mode, 0: burst mode |
| usr_ready | output | 1 | READY |
| usr_busy | output | 1 | BUSY with the selected polarity |
| usr_endcy | output | 1 | End-of-cycle pulse |
| usr_go | output | 1 | GO pulse |
| usr_init | output | 1 | INIT level |
| usr_initv2 | output | 1 | INITV2 pulse |
| usr_fnct | output | 3 | Function bits |
| dma_req_valid | output | 1 | Word request to the DMA engine |
| dma_req_dir | output | 1 | 1: word goes user to memory |
| dma_req_ready | input | 1 | DMA engine accepts or completes the word |

## Verification
Transfers are run in single-cycle and burst mode, in both directions, with fast and slow timing, and with the DMA engine answering at once or five clocks late. The measured BUSY width separates the setup rule from the minimum-active rule. The input direction shows that setup applies only to output data. A request raised while READY is high tells a gated start from an ungated one. A request raised mid-transfer, with and without a later bus error, separates pending service from pending discard. Repeated writes of function bit 2 show that only its rising edge fires INITV2.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2,
    ST_END  = 2'd3
  } hs_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_pulse.sv
module hs_pulse #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig)       cnt <= CW'(LEN);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/hs_cycle_fsm.sv
module hs_cycle_fsm
  import hs_pkg::*;
#(
  parameter int SETUP_FAST = 20,
  parameter int SETUP_SLOW = 40,
  parameter int BUSY_FAST  = 30,
  parameter int BUSY_SLOW  = 50,
  parameter int ENDCY_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_edge,
  input  logic abort,
  input  logic ready_q,
  input  logic single,
  input  logic dir_in,
  input  logic slow,
  input  logic dma_ready,
  output logic dma_valid,
  output logic dma_dir,
  output logic busy_act,
  output logic endcy
);
  localparam int MAXV  = imax(imax(SETUP_FAST, SETUP_SLOW),
                              imax(imax(BUSY_FAST, BUSY_SLOW), ENDCY_CLKS));
  localparam int CNT_W = $clog2(MAXV + 2) + 1;

  hs_state_e        state;
  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] scnt;
  logic             dir_q;
  logic             pending;
  logic [CNT_W-1:0] setup_lim;
  logic [CNT_W-1:0] busy_lim;
  logic             hold_done;
  logic             end_done;
  logic             start_idle;
  logic             restart;

  assign setup_lim = slow ? CNT_W'(SETUP_SLOW) : CNT_W'(SETUP_FAST);
  assign busy_lim  = slow ? CNT_W'(BUSY_SLOW)  : CNT_W'(BUSY_FAST);

  always_comb begin
    hold_done  = (dir_q || ((scnt + CNT_W'(1)) >= setup_lim)) &&
                 (single || ((bcnt + CNT_W'(1)) >= busy_lim));
    end_done   = (scnt + CNT_W'(1)) >= CNT_W'(ENDCY_CLKS);
    start_idle = (req_edge || pending) && !ready_q;
    restart    = !ready_q && (!single || pending || req_edge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bcnt    <= '0;
      scnt    <= '0;
      dir_q   <= 1'b0;
      pending <= 1'b0;
    end else if (abort) begin
      state   <= ST_IDLE;
      bcnt    <= '0;
      scnt    <= '0;
      pending <= 1'b0;
    end else begin
      if (req_edge && state != ST_IDLE) pending <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (start_idle) begin
            state   <= ST_REQ;
            bcnt    <= '0;
            dir_q   <= dir_in;
            pending <= 1'b0;
          end
        end
        ST_REQ: begin
          bcnt <= bcnt + CNT_W'(1);
          if (dma_ready) begin
            state <= ST_HOLD;
            scnt  <= '0;
          end
        end
        ST_HOLD: begin
          bcnt <= bcnt + CNT_W'(1);
          scnt <= scnt + CNT_W'(1);
          if (hold_done) begin
            state <= ST_END;
            scnt  <= '0;
          end
        end
        ST_END: begin
          scnt <= scnt + CNT_W'(1);
          if (end_done) begin
            pending <= 1'b0;
            scnt    <= '0;
            if (restart) begin
              state <= ST_REQ;
              bcnt  <= '0;
              dir_q <= dir_in;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dma_valid = (state == ST_REQ);
  assign busy_act  = (state == ST_REQ) || (state == ST_HOLD);
  assign endcy     = (state == ST_END);
  assign dma_dir   = dir_q;
endmodule

// File: rtl/dma_user_handshake.sv
module dma_user_handshake #(
  parameter int GO_CLKS     = 20,
  parameter int INITV2_CLKS = 20,
  parameter int ENDCY_CLKS  = 10,
  parameter int SETUP_FAST  = 20,
  parameter int SETUP_SLOW  = 40,
  parameter int BUSY_FAST   = 30,
  parameter int BUSY_SLOW   = 50,
  parameter int FN_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_go_wr,
  input  logic            ctl_fn_wr,
  input  logic [FN_W-1:0] ctl_fn_data,
  input  logic            ctl_init_sw,
  input  logic            ctl_busy_hi,
  input  logic            ctl_slow,
  input  logic            bus_err,
  output logic [7:0]      status_byte,
  input  logic            usr_cycrq_a,
  input  logic            usr_cycrq_b,
  input  logic            usr_attn,
  input  logic            usr_dir_in,
  input  logic            usr_c0,
  input  logic            usr_a0,
  input  logic [2:0]      usr_stat,
  input  logic            usr_single,
  output logic            usr_ready,
  output logic            usr_busy,
  output logic            usr_endcy,
  output logic            usr_go,
  output logic            usr_init,
  output logic            usr_initv2,
  output logic [FN_W-1:0] usr_fnct,
  output logic            dma_req_valid,
  output logic            dma_req_dir,
  input  logic            dma_req_ready
);
  localparam int SW = 9;

  logic [SW-1:0]   raw_in;
  logic [SW-1:0]   syn_in;
  logic            rq_s, attn_s, dir_s, single_s, c0_s, a0_s;
  logic [2:0]      stat_s;
  logic            rq_q;
  logic            req_edge;
  logic            abort_evt;
  logic            ready_q;
  logic [FN_W-1:0] fn_q;
  logic            iv_trig;
  logic            iv_pulse;
  logic            busy_act;

  assign raw_in = {usr_cycrq_a | usr_cycrq_b, usr_attn, usr_dir_in, usr_single,
                   usr_stat, usr_c0, usr_a0};

  hs_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {rq_s, attn_s, dir_s, single_s, stat_s, c0_s, a0_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq_q <= 1'b0;
    else        rq_q <= rq_s;
  end

  assign req_edge  = rq_s && !rq_q;
  assign abort_evt = attn_s || bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ready_q <= 1'b1;
    else if (abort_evt)  ready_q <= 1'b1;
    else if (ctl_go_wr)  ready_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fn_q <= '0;
    else if (ctl_fn_wr) fn_q <= ctl_fn_data;
  end

  assign iv_trig = ctl_fn_wr && ctl_fn_data[1] && !fn_q[1];

  hs_pulse #(.LEN(GO_CLKS)) u_go_pulse (
    .clk(clk), .rst_n(rst_n), .trig(ctl_go_wr), .pulse(usr_go)
  );

  hs_pulse #(.LEN(INITV2_CLKS)) u_iv_pulse (
    .clk(clk), .rst_n(rst_n), .trig(iv_trig), .pulse(iv_pulse)
  );

  hs_cycle_fsm #(
    .SETUP_FAST(SETUP_FAST), .SETUP_SLOW(SETUP_SLOW),
    .BUSY_FAST(BUSY_FAST),   .BUSY_SLOW(BUSY_SLOW),
    .ENDCY_CLKS(ENDCY_CLKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_edge(req_edge), .abort(abort_evt),
    .ready_q(ready_q), .single(single_s), .dir_in(dir_s), .slow(ctl_slow),
    .dma_ready(dma_req_ready), .dma_valid(dma_req_valid), .dma_dir(dma_req_dir),
    .busy_act(busy_act), .endcy(usr_endcy)
  );

  assign usr_ready   = ready_q;
  assign usr_busy    = ctl_busy_hi ? busy_act : !busy_act;
  assign usr_init    = !rst_n || ctl_init_sw;
  assign usr_initv2  = !rst_n || iv_pulse;
  assign usr_fnct    = fn_q;
  assign status_byte = {ready_q, 1'b0, stat_s, 1'b0, c0_s, a0_s};
endmodule

// File: rtl/dma_user_handshake_chk.sv
module dma_user_handshake_chk #(
  parameter int ENDCY_CLKS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic go_wr,
  input logic abort,
  input logic dma_valid,
  input logic dma_ready,
  input logic dma_dir,
  input logic ready,
  input logic busy_act,
  input logic endcy
);
  localparam int RW = $clog2(ENDCY_CLKS + 2) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= '0;
    else if (endcy) run <= run + RW'(1);
    else            run <= '0;
  end

  // R2
  go_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_wr && !abort |=> !ready);

  // R4
  abort_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> ready && !dma_valid && !busy_act);

  // R3
  start_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_valid) |-> !ready);

  // R12
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready && !abort |=> dma_valid && $stable(dma_dir));

  // R5
  endcy_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(endcy && busy_act));

  // R5
  endcy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(endcy) && !$past(abort) |-> run == RW'(ENDCY_CLKS));
endmodule

bind dma_user_handshake dma_user_handshake_chk #(.ENDCY_CLKS(ENDCY_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_wr(ctl_go_wr), .abort(abort_evt),
  .dma_valid(dma_req_valid), .dma_ready(dma_req_ready), .dma_dir(dma_req_dir),
  .ready(usr_ready), .busy_act(busy_act), .endcy(usr_endcy)
);

// File: tb/dma_user_handshake_tb.sv
`timescale 1ns/1ps
module dma_user_handshake_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_go_wr = 0, ctl_fn_wr = 0, ctl_init_sw = 0, ctl_busy_hi = 0, ctl_slow = 0, bus_err = 0;
  logic [2:0] ctl_fn_data = '0;
  logic [7:0] status_byte;
  logic usr_cycrq_a = 0, usr_cycrq_b = 0, usr_attn = 0, usr_dir_in = 0, usr_c0 = 0, usr_a0 = 0;
  logic [2:0] usr_stat = '0;
  logic usr_single = 1;
  logic usr_ready, usr_busy, usr_endcy, usr_go, usr_init, usr_initv2;
  logic [2:0] usr_fnct;
  logic dma_req_valid, dma_req_dir;
  logic dma_req_ready = 0;

  int checks = 0, errors = 0;
  int eng_delay = 0, wait_cnt = 0;
  int bsy_run = 0, last_busy_w = 0, endcy_run = 0, last_endcy_w = 0, endcy_falls = 0;
  int go_run = 0, last_go_w = 0, iv_run = 0, last_iv_w = 0, iv_pulses = 0;
  int hs_count = 0, valid_drops = 0;
  logic last_dir = 0, prev_wait = 0, prev_iv = 0;

  always #2.5 clk = ~clk;

  dma_user_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_go_wr(ctl_go_wr), .ctl_fn_wr(ctl_fn_wr),
    .ctl_fn_data(ctl_fn_data), .ctl_init_sw(ctl_init_sw), .ctl_busy_hi(ctl_busy_hi),
    .ctl_slow(ctl_slow), .bus_err(bus_err), .status_byte(status_byte),
    .usr_cycrq_a(usr_cycrq_a), .usr_cycrq_b(usr_cycrq_b), .usr_attn(usr_attn),
    .usr_dir_in(usr_dir_in), .usr_c0(usr_c0), .usr_a0(usr_a0), .usr_stat(usr_stat),
    .usr_single(usr_single), .usr_ready(usr_ready), .usr_busy(usr_busy),
    .usr_endcy(usr_endcy), .usr_go(usr_go), .usr_init(usr_init), .usr_initv2(usr_initv2),
    .usr_fnct(usr_fnct), .dma_req_valid(dma_req_valid), .dma_req_dir(dma_req_dir),
    .dma_req_ready(dma_req_ready)
  );

  function automatic logic bsy();
    return ctl_busy_hi ? usr_busy : !usr_busy;
  endfunction

  // DMA engine model: answers eng_delay clocks after a request appears
  initial forever begin
    @(posedge clk); #1;
    if (dma_req_ready) begin
      dma_req_ready = 1'b0;
      wait_cnt = 0;
    end else if (dma_req_valid) begin
      if (wait_cnt >= eng_delay) dma_req_ready = 1'b1;
      else wait_cnt++;
    end else begin
      wait_cnt = 0;
    end
  end

  // Port monitor, sampled on the falling edge
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (bsy()) bsy_run++;
      else if (bsy_run != 0) begin last_busy_w = bsy_run; bsy_run = 0; end
      if (usr_endcy) endcy_run++;
      else if (endcy_run != 0) begin last_endcy_w = endcy_run; endcy_run = 0; endcy_falls++; end
      if (usr_go) go_run++;
      else if (go_run != 0) begin last_go_w = go_run; go_run = 0; end
      if (usr_initv2) iv_run++;
      else if (iv_run != 0) begin last_iv_w = iv_run; iv_run = 0; end
      if (usr_initv2 && !prev_iv) iv_pulses++;
      prev_iv = usr_initv2;
      if (dma_req_valid && dma_req_ready) begin hs_count++; last_dir = dma_req_dir; end
      if (prev_wait && !dma_req_valid && !usr_ready) valid_drops++;
      prev_wait = dma_req_valid && !dma_req_ready;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_write();
    @(negedge clk); ctl_go_wr = 1;
    @(negedge clk); ctl_go_wr = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); usr_cycrq_a = 1;
    cyc(4); usr_cycrq_a = 0;
  endtask

  task automatic wait_endcy(input int target, input string req);
    int n = 0;
    while (endcy_falls < target && n < 3000) begin @(negedge clk); n++; end
    chk(endcy_falls >= target, req, endcy_falls, target);
  endtask

  task automatic t_reset();
    cyc(3);
    chk(usr_ready == 1, "R1 ready", usr_ready, 1);
    chk(usr_init == 1 && usr_initv2 == 1, "R1 init", {usr_init, usr_initv2}, 3);
    chk(usr_busy == 1 && usr_endcy == 0, "R1 busy", {usr_busy, usr_endcy}, 2);
    chk(dma_req_valid == 0, "R1 valid", dma_req_valid, 0);
    @(negedge clk); rst_n = 1;
    cyc(3);
    chk(usr_init == 0 && usr_initv2 == 0, "R1 init release", {usr_init, usr_initv2}, 0);
  endtask

  task automatic t_ignored_when_ready();
    int base = hs_count;
    pulse_req();
    cyc(40);
    chk(hs_count == base && !bsy(), "R3 edge while ready", hs_count, base);
    go_write();
    cyc(40);
    chk(hs_count == base, "R3 not remembered", hs_count, base);
  endtask

  task automatic t_go();
    go_write();
    cyc(1);
    chk(usr_ready == 0, "R2 ready cleared", usr_ready, 0);
    cyc(25);
    chk(last_go_w == 20, "R2 go width", last_go_w, 20);
  endtask

  task automatic t_single(input bit slow, input bit din, input int dly, input int exp_w, input string req);
    int base = endcy_falls;
    ctl_slow = slow; usr_dir_in = din; eng_delay = dly; usr_single = 1;
    cyc(3);
    usr_cycrq_b = 1; cyc(4); usr_cycrq_b = 0;
    wait_endcy(base + 1, req);
    chk(last_busy_w == exp_w, req, last_busy_w, exp_w);
    chk(last_endcy_w == 10, "R5 endcy width", last_endcy_w, 10);
    chk(last_dir == din, "R12 dir", last_dir, din);
    cyc(30);
    chk(endcy_falls == base + 1, "R8 one transfer per request", endcy_falls, base + 1);
  endtask

  task automatic t_burst(input bit slow, input int exp_w, input string req);
    int base = endcy_falls;
    ctl_slow = slow; usr_dir_in = 0; eng_delay = 0; usr_single = 0;
    cyc(3);
    pulse_req();
    wait_endcy(base + 3, req);
    chk(last_busy_w == exp_w, req, last_busy_w, exp_w);
    @(negedge clk); usr_attn = 1;
    cyc(6);
    chk(usr_ready == 1 && !bsy() && !dma_req_valid, "R4 attn abort", usr_ready, 1);
    usr_attn = 0; usr_single = 1;
    cyc(5);
    go_write();
    cyc(2);
    chk(usr_ready == 0, "R2 re-arm", usr_ready, 0);
  endtask

  task automatic t_polarity();
    ctl_busy_hi = 1; ctl_slow = 0; usr_dir_in = 0; eng_delay = 0;
    cyc(2);
    chk(usr_busy == 0, "R6 idle high-true", usr_busy, 0);
    usr_cycrq_a = 1; cyc(6);
    chk(usr_busy == 1, "R6 active high-true", usr_busy, 1);
    usr_cycrq_a = 0;
    cyc(40);
    ctl_busy_hi = 0; cyc(1);
    chk(usr_busy == 1, "R6 idle low-true", usr_busy, 1);
  endtask

  task automatic t_pending();
    int base = endcy_falls;
    usr_single = 1; ctl_slow = 0; usr_dir_in = 0; eng_delay = 0;
    usr_cycrq_a = 1; cyc(6);
    usr_cycrq_a = 0; cyc(3); usr_cycrq_a = 1;
    wait_endcy(base + 2, "R9 pending served");
    usr_cycrq_a = 0;
    cyc(40);
    chk(endcy_falls == base + 2, "R9 exactly two", endcy_falls, base + 2);
    base = endcy_falls;
    usr_cycrq_a = 1; cyc(6);
    usr_cycrq_a = 0; cyc(3); usr_cycrq_a = 1; cyc(5);
    @(negedge clk); bus_err = 1; @(negedge clk); bus_err = 0;
    cyc(2);
    chk(usr_ready == 1 && !bsy(), "R4 bus error", usr_ready, 1);
    usr_cycrq_a = 0;
    cyc(10);
    go_write();
    cyc(80);
    chk(endcy_falls == base, "R9 pending discarded", endcy_falls, base);
    chk(valid_drops == 0, "R12 valid held", valid_drops, 0);
  endtask

  task automatic t_fnct();
    int base = iv_pulses;
    @(negedge clk); ctl_fn_wr = 1; ctl_fn_data = 3'b010;
    @(negedge clk); ctl_fn_wr = 0;
    cyc(25);
    chk(usr_fnct == 3'b010, "R10 fnct", usr_fnct, 2);
    chk(iv_pulses == base + 1 && last_iv_w == 20, "R10 initv2 width", last_iv_w, 20);
    @(negedge clk); ctl_fn_wr = 1; ctl_fn_data = 3'b111;
    @(negedge clk); ctl_fn_wr = 0;
    cyc(25);
    chk(iv_pulses == base + 1, "R10 no re-fire", iv_pulses, base + 1);
    chk(usr_fnct == 3'b111, "R10 fnct 2", usr_fnct, 7);
    ctl_init_sw = 1; cyc(1);
    chk(usr_init == 1, "R10 init sw", usr_init, 1);
    ctl_init_sw = 0; cyc(1);
    chk(usr_init == 0, "R10 init sw off", usr_init, 0);
  endtask

  task automatic t_status();
    usr_stat = 3'b101; usr_c0 = 1; usr_a0 = 0;
    cyc(4);
    chk(status_byte[6:0] == 7'b0101010 && status_byte[7] == usr_ready, "R11 status a",
        status_byte, {usr_ready, 7'b0101010});
    usr_stat = 3'b010; usr_c0 = 0; usr_a0 = 1;
    cyc(4);
    chk(status_byte[6:0] == 7'b0010001 && status_byte[7] == usr_ready, "R11 status b",
        status_byte, {usr_ready, 7'b0010001});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ignored_when_ready();
    t_go();
    t_single(0, 0, 0, 21, "R8 single out fast");
    t_single(0, 0, 5, 26, "R8 single out late engine");
    t_single(0, 1, 0, 2, "R8 single in");
    t_single(1, 0, 0, 41, "R8 single out slow");
    t_burst(0, 30, "R7 burst fast");
    t_burst(1, 50, "R7 burst slow");
    t_polarity();
    t_pending();
    t_fnct();
    t_status();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule